// File: doc/BRIEF.md
# Cascadable Reload Timer Pair with PWM

This block holds two 8-bit down-counters, timer A and timer B. Each has its own reload latch, a stop control and a 2-bit count-source select. A counter that has reached zero reloads from its latch on the next count pulse. On that pulse it also raises a one-cycle interrupt and flips a square-wave output, so the output runs at half the underflow rate. Timer B can count the underflows of timer A, which chains the two into a longer divider. Either timer can count a synchronized external input, and a control bit picks which edge of that input is active.

Timer B also has a PWM mode. In this mode its output is high for a number of count pulses equal to its reload latch (n), then low for a number equal to a separate low-length register (m). A zero in either length forces the output to a fixed level. The interrupt then marks the start of each high phase. Software sets up the block through a small byte-wide register bus with four addresses. A built-in prescaler supplies count ticks at 1/16, 1/32 and 1/128 of the clock rate.

Top module: `cascade_timer`

## Requirements
- R1: A counter decrements on each count pulse. On a count pulse that finds it at 00 it reloads from its latch instead, and the timer's interrupt output goes high for exactly one cycle. The latch is written at address 0 (timer A) or address 1 (timer B), and reading that address returns the live counter.
- R2: Mode register bit 0 (timer A) or bit 1 (timer B) set to 1 freezes the counter; clearing it lets counting resume from the held value.
- R3: Timer A source, mode bits [3:2]: 00 = clock/16, 01 = clock/32, 10 = clock/128, 11 = external input. Timer B source, mode bits [5:4]: 00 = clock/16, 01 = timer A underflow, 10 = external input, 11 = clock/128.
- R4: Outside PWM mode, a timer's output starts at 0 after reset and inverts on every underflow of that timer.
- R5: With mode bit 6 set, timer B runs in PWM mode. Its output starts high and stays high for n count pulses, then low for m count pulses, and repeats. Here n is the timer B latch and m is the low-length register at address 2.
- R6: In PWM mode, n = 0 holds the output low, and m = 0 with n non-zero holds it high. n = 0 wins when both are 0.
- R7: In PWM mode, timer B's interrupt pulses only when the output goes from low to high between the two lengths. It stays quiet while either length is zero.
- R8: After reset the mode register (address 3) and the low-length register read 00, timer A holds FF, timer B holds 01, and both outputs and interrupts are 0.
- R9: A latch write while the timer is stopped also loads the counter at once. While the timer runs, the write changes only the value taken at the next reload.
- R10: The external input passes through a two-stage synchronizer. Mode bit 7 = 0 counts rising edges and 1 counts falling edges, one count pulse per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (counter A, counter B, low length, mode) |
| ext_i | input | 1 | External count input, asynchronous |
| irq_a_o | output | 1 | Timer A interrupt pulse |
| irq_b_o | output | 1 | Timer B interrupt pulse |
| out_a_o | output | 1 | Timer A square-wave output |
| out_b_o | output | 1 | Timer B square-wave or PWM output |

## Verification
Two events can land in the same cycle: timer A's underflow and timer B's count pulse, because timer B takes that underflow as its count source. The bench chains the timers with short latches and drives the external input to clock timer A. Timer B's reload then happens on the very pulse where timer A reloads. The bench judges the result from the interrupt counts of both timers and from both counter values read back through the bus. A second collision, a latch write against a running count, is judged by checking that the counter keeps its value until the next reload.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam logic [1:0] ADDR_TMR_A = 2'd0;
  localparam logic [1:0] ADDR_TMR_B = 2'd1;
  localparam logic [1:0] ADDR_LOW   = 2'd2;
  localparam logic [1:0] ADDR_MODE  = 2'd3;

  typedef struct packed {
    logic       ext_fall;
    logic       pwm_b;
    logic [1:0] src_b;
    logic [1:0] src_a;
    logic       stop_b;
    logic       stop_a;
  } mode_t;

  localparam logic [1:0] SRC_A_DIV16 = 2'b00;
  localparam logic [1:0] SRC_A_DIV32 = 2'b01;
  localparam logic [1:0] SRC_A_DIV128 = 2'b10;
  localparam logic [1:0] SRC_A_EXT   = 2'b11;

  localparam logic [1:0] SRC_B_DIV16 = 2'b00;
  localparam logic [1:0] SRC_B_CASC  = 2'b01;
  localparam logic [1:0] SRC_B_EXT   = 2'b10;
  localparam logic [1:0] SRC_B_DIV128 = 2'b11;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int N_TAPS = 3,
  parameter int TAP_LOG [N_TAPS] = '{4, 5, 7}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [N_TAPS-1:0] tick_o
);
  localparam int CW = TAP_LOG[N_TAPS-1];

  logic [CW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign tick_o[t] = &div_q[TAP_LOG[t]-1:0];
  end

  // taps ascend, so the slowest tick always coincides with all faster ones
  AST_TAP_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[N_TAPS-1] |-> (&tick_o)); // R3
endmodule

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic fall_i,
  output logic tick_o
);
  localparam int SW = STAGES + 1;

  logic [SW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SW-2:0], ext_i};
  end

  logic cur, prev;
  assign cur  = sh_q[SW-2];
  assign prev = sh_q[SW-1];
  assign tick_o = fall_i ? (prev & ~cur) : (~prev & cur);

  AST_EXT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $stable(fall_i)) |=> !tick_o); // R10
endmodule

// File: rtl/ct_timer.sv
module ct_timer #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '1,
  parameter bit           PWM_CAP = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pulse_i,
  input  logic         stop_i,
  input  logic         latch_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] low_len_i,
  input  logic         pwm_en_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o,
  output logic         irq_o,
  output logic         out_o
);
  logic [W-1:0] cnt_q, latch_q;
  logic         tog_q, phase_q, irq_q;
  logic         pwm_act, tick, at_zero, pwm_sw, n_zero, m_zero;

  assign pwm_act = PWM_CAP ? pwm_en_i : 1'b0;
  assign tick    = pulse_i & ~stop_i;
  assign at_zero = (cnt_q == '0);
  assign uf_o    = tick & at_zero & ~pwm_act;
  // phase ends on the pulse that finds 1 (or 0 after a zero-length load)
  assign pwm_sw  = tick & pwm_act & (cnt_q < W'(2));
  assign n_zero  = (latch_q == '0);
  assign m_zero  = (low_len_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= RST_VAL;
    else if (latch_wr_i) latch_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL;
    end else if (latch_wr_i && stop_i) begin
      cnt_q <= wdata_i;
    end else if (tick) begin
      if (pwm_act) begin
        if (cnt_q < W'(2)) cnt_q <= phase_q ? low_len_i : latch_q;
        else               cnt_q <= cnt_q - 1'b1;
      end else if (at_zero) begin
        cnt_q <= latch_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= 1'b1;
    else if (!pwm_act) phase_q <= 1'b1;
    else if (pwm_sw)   phase_q <= ~phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tog_q <= 1'b0;
    else if (uf_o) tog_q <= ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (pwm_act) irq_q <= pwm_sw & ~phase_q & ~n_zero & ~m_zero;
    else              irq_q <= uf_o;
  end

  always_comb begin
    if (!pwm_act)    out_o = tog_q;
    else if (n_zero) out_o = 1'b0;
    else if (m_zero) out_o = 1'b1;
    else             out_o = phase_q;
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_RELOAD_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && at_zero && !pwm_act) |=> (cnt_q == $past(latch_q))); // R1
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !latch_wr_i) |=> $stable(cnt_q)); // R2
  AST_TOGGLE_ON_UF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(pwm_act)) |-> (tog_q != $past(tog_q))); // R4
  AST_PWM_IRQ_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && pwm_act && !n_zero && !m_zero) |-> out_o); // R7
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_A   = 8'hFF,
  parameter logic [W-1:0] RST_B   = 8'h01,
  parameter int           SYNC_ST = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         ext_i,
  output logic         irq_a_o,
  output logic         irq_b_o,
  output logic         out_a_o,
  output logic         out_b_o
);
  import ct_pkg::*;

  localparam int N_TAPS = 3;

  mode_t        mode_q;
  logic [W-1:0] low_q, cnt_a, cnt_b;
  logic [N_TAPS-1:0] pre_tick;
  logic         ext_tick, uf_a, uf_b, pulse_a, pulse_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      low_q  <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_MODE) mode_q <= mode_t'(wdata_i[7:0]);
      if (addr_i == ADDR_LOW)  low_q  <= wdata_i;
    end
  end

  ct_prescaler #(.N_TAPS(N_TAPS), .TAP_LOG('{4, 5, 7})) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(pre_tick)
  );

  ct_edge_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_i),
    .fall_i(mode_q.ext_fall),
    .tick_o(ext_tick)
  );

  always_comb begin
    unique case (mode_q.src_a)
      SRC_A_DIV16:  pulse_a = pre_tick[0];
      SRC_A_DIV32:  pulse_a = pre_tick[1];
      SRC_A_DIV128: pulse_a = pre_tick[2];
      default:      pulse_a = ext_tick;
    endcase
    unique case (mode_q.src_b)
      SRC_B_DIV16:  pulse_b = pre_tick[0];
      SRC_B_CASC:   pulse_b = uf_a;
      SRC_B_EXT:    pulse_b = ext_tick;
      default:      pulse_b = pre_tick[2];
    endcase
  end

  ct_timer #(.W(W), .RST_VAL(RST_A), .PWM_CAP(1'b0)) u_tmr_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (pulse_a),
    .stop_i    (mode_q.stop_a),
    .latch_wr_i(we_i && addr_i == ADDR_TMR_A),
    .wdata_i   (wdata_i),
    .low_len_i ('0),
    .pwm_en_i  (1'b0),
    .cnt_o     (cnt_a),
    .uf_o      (uf_a),
    .irq_o     (irq_a_o),
    .out_o     (out_a_o)
  );

  ct_timer #(.W(W), .RST_VAL(RST_B), .PWM_CAP(1'b1)) u_tmr_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (pulse_b),
    .stop_i    (mode_q.stop_b),
    .latch_wr_i(we_i && addr_i == ADDR_TMR_B),
    .wdata_i   (wdata_i),
    .low_len_i (low_q),
    .pwm_en_i  (mode_q.pwm_b),
    .cnt_o     (cnt_b),
    .uf_o      (uf_b),
    .irq_o     (irq_b_o),
    .out_o     (out_b_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_TMR_A: rdata_o = cnt_a;
      ADDR_TMR_B: rdata_o = cnt_b;
      ADDR_LOW:   rdata_o = low_q;
      default:    rdata_o = W'(mode_q);
    endcase
  end

  AST_CASCADE_FEEDS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.src_b == SRC_B_CASC && !mode_q.stop_b && !mode_q.pwm_b && uf_a && cnt_b != '0
     && !(we_i && addr_i == ADDR_MODE))
    |=> (cnt_b == $past(cnt_b) - 1'b1)); // R3

  logic unused_uf_b;
  assign unused_uf_b = uf_b;
endmodule

// File: tb/cascade_timer_tb_top.sv
`timescale 1ns/1ps
module cascade_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext = 1'b0;
  logic       irq_a, irq_b, out_a, out_b;

  int n_chk = 0;
  int n_bad = 0;
  int n_irq_a = 0;
  int n_irq_b = 0;

  always #4 clk = ~clk;

  cascade_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_i(ext), .irq_a_o(irq_a), .irq_b_o(irq_b),
    .out_a_o(out_a), .out_b_o(out_b)
  );

  always @(negedge clk) begin
    if (irq_a) n_irq_a++;
    if (irq_b) n_irq_b++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic ext_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext = 1'b1;
      repeat (6) @(negedge clk);
      ext = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic clr_irq();
    @(negedge clk);
    n_irq_a = 0; n_irq_b = 0;
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk); addr = 2'd0; #1;
    chk("R8 cnt A", int'(rdata), 8'hFF);
    addr = 2'd1; #1;
    chk("R8 cnt B", int'(rdata), 8'h01);
    addr = 2'd3; #1;
    chk("R8 mode", int'(rdata), 0);
    addr = 2'd2; #1;
    chk("R8 low len", int'(rdata), 0);
    chk("R8 outputs", int'({out_a, out_b, irq_a, irq_b}), 0);
    wr(2'd3, 8'h03);
    rd(2'd3, v);
    chk("R8 mode write", v, 8'h03);
  endtask

  task automatic t_stop_load();
    int v;
    wr(2'd0, 8'd3);
    rd(2'd0, v);
    chk("R9 stopped load", v, 3);
    wr(2'd3, 8'h0F);
    ext_pulse(1);
    rd(2'd0, v);
    chk("R2 stopped holds", v, 3);
  endtask

  task automatic t_count_reload();
    int v;
    clr_irq();
    wr(2'd3, 8'h0E);
    ext_pulse(3);
    rd(2'd0, v);
    chk("R1 count to zero", v, 0);
    chk("R1 no irq yet", n_irq_a, 0);
    wr(2'd0, 8'd5);
    rd(2'd0, v);
    chk("R9 running write deferred", v, 0);
    ext_pulse(1);
    rd(2'd0, v);
    chk("R1 reload", v, 5);
    chk("R1 irq once", n_irq_a, 1);
    chk("R4 out after 1st uf", int'(out_a), 1);
    ext_pulse(6);
    rd(2'd0, v);
    chk("R1 second reload", v, 5);
    chk("R1 irq twice", n_irq_a, 2);
    chk("R4 out after 2nd uf", int'(out_a), 0);
    wr(2'd3, 8'h0F);
    ext_pulse(1);
    rd(2'd0, v);
    chk("R2 stop", v, 5);
    wr(2'd3, 8'h0E);
    ext_pulse(1);
    rd(2'd0, v);
    chk("R2 resume", v, 4);
  endtask

  task automatic t_polarity();
    int v;
    wr(2'd3, 8'h8E);
    @(negedge clk); ext = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd0, v);
    chk("R10 rise ignored in falling mode", v, 4);
    @(negedge clk); ext = 1'b0;
    repeat (8) @(negedge clk);
    rd(2'd0, v);
    chk("R10 falling edge counts", v, 3);
  endtask

  task automatic t_cascade();
    int v;
    wr(2'd3, 8'h03);
    wr(2'd0, 8'd1);
    wr(2'd1, 8'd2);
    clr_irq();
    wr(2'd3, 8'h1C);
    ext_pulse(6);
    rd(2'd1, v);
    chk("R3 cascade B reloaded", v, 2);
    chk("R3 cascade B irq", n_irq_b, 1);
    chk("R3 cascade A irq", n_irq_a, 3);
    rd(2'd0, v);
    chk("R3 cascade A value", v, 1);
  endtask

  task automatic t_prescale();
    int v;
    wr(2'd3, 8'h03);
    wr(2'd0, 8'd10);
    wr(2'd3, 8'h02);
    repeat (150) @(negedge clk);
    rd(2'd0, v);
    chk("R3 div16 rate", int'(v <= 1), 1);
  endtask

  task automatic t_pwm();
    int v;
    wr(2'd3, 8'h03);
    wr(2'd1, 8'd2);
    wr(2'd2, 8'd3);
    wr(2'd3, 8'h61);
    clr_irq();
    chk("R5 starts high", int'(out_b), 1);
    ext_pulse(1);
    chk("R5 high after 1", int'(out_b), 1);
    ext_pulse(1);
    chk("R5 low after n", int'(out_b), 0);
    chk("R7 no irq on fall", n_irq_b, 0);
    ext_pulse(2);
    chk("R5 low through m", int'(out_b), 0);
    ext_pulse(1);
    chk("R5 high after m", int'(out_b), 1);
    chk("R7 irq on rise", n_irq_b, 1);
    wr(2'd2, 8'd0);
    chk("R6 m zero high", int'(out_b), 1);
    clr_irq();
    ext_pulse(4);
    chk("R6 m zero stays high", int'(out_b), 1);
    chk("R7 no irq while m zero", n_irq_b, 0);
    wr(2'd1, 8'd0);
    chk("R6 n zero wins", int'(out_b), 0);
    wr(2'd2, 8'd3);
    ext_pulse(3);
    chk("R6 n zero stays low", int'(out_b), 0);
    chk("R7 no irq while n zero", n_irq_b, 0);
    rd(2'd2, v);
    chk("R5 low len readback", v, 3);
  endtask

  bit done = 1'b0;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stop_load();
    t_count_reload();
    t_polarity();
    t_cascade();
    t_prescale();
    t_pwm();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule